// File: doc/BRIEF.md
# System-Management Memory Window Decoder

This block is a single registered decode stage placed between a processor request port and the port that routes requests to DRAM or to the I/O side. Every request address is compared against three system-management memory windows. The first is a fixed low window that maps one-to-one onto DRAM. The second is a fixed high window that is remapped down onto the same DRAM bytes as the low window. The third is a top segment whose base is computed at run time from the top of low memory, the stolen-memory size and a selectable segment size.

For each request the block reports the address to forward and whether the request goes to DRAM. A window hit that the access rules refuse is either passed to the legacy I/O path unchanged or flagged as blocked. The rules depend on the requester's system-management mode, on whether the access is a code fetch or a data access, and on an open control and a close control. Setting both controls at once is illegal. In that case the block raises a configuration-error flag and behaves as if only the close control were set.

The configuration inputs are captured into shadow registers only in cycles with no request strobe. Each result appears on the outputs one clock after its request.

Top module: `smm_window_decoder`

## Requirements
- R1: While reset is asserted, rsp_valid, rsp_dram, rsp_blocked, cfg_err and rsp_addr are all zero.
- R2: When the access is allowed, an address from 0x000A_0000 to 0x000B_FFFF (both ends included) in the enabled low window goes to DRAM with the address unchanged.
- R3: When the access is allowed, an address from 0xFEDA_0000 to 0xFEDB_FFFF in the enabled high window goes to DRAM at the bus address minus 0xFED0_0000. No DRAM-bound output address ever lies inside the high bus range.
- R4: The segment window covers the range base <= addr < top, with top = tolm - stolen and base = top - size. The size is selected by cfg_seg_sel: 00 = 1 MiB, 01 = 2 MiB, 10 = 8 MiB. The code 11 disables the segment window, and so does any borrow in either subtraction.
- R5: If both cfg_open and cfg_close are sampled set, cfg_err reads 1 and the decoder acts as if only close were set. Otherwise cfg_err reads 0.
- R6: With open set (and close clear), a hit in any window goes to DRAM even when req_smm is 0.
- R7: With close set, an SMM data access (req_code=0) to the low window goes to the legacy path (rsp_dram=0, rsp_blocked=0, address unchanged). The same access to the high window is blocked (rsp_blocked=1). SMM code fetches and segment hits still go to DRAM.
- R8: When req_smm is 0 and open is not in effect, no request goes to DRAM. A low-window hit goes to the legacy path with its address unchanged, and a high-window or segment hit sets rsp_blocked.
- R9: An address outside every enabled window is forwarded unchanged with rsp_dram=0 and rsp_blocked=0.
- R10: rsp_valid follows req_valid one clock later. The response fields hold their values in cycles without a request. Configuration inputs that change while req_valid is high have no effect until a cycle with req_valid low.
- R11: Clearing a window's enable bit makes addresses in that window behave as misses.
- R12: rsp_dram and rsp_blocked are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Request bus address |
| req_smm | input | 1 | Requester is in system-management mode |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| cfg_low_en | input | 1 | Low window enable |
| cfg_high_en | input | 1 | High window enable |
| cfg_seg_en | input | 1 | Segment window enable |
| cfg_open | input | 1 | Open control: DRAM windows reachable outside SMM |
| cfg_close | input | 1 | Close control: SMM data kept out of low/high windows |
| cfg_tolm | input | AW | Top of low memory |
| cfg_stolen | input | AW | Stolen memory size below top of low memory |
| cfg_seg_sel | input | 2 | Segment size select |
| rsp_valid | output | 1 | Response strobe, one clock after request |
| rsp_addr | output | AW | Forwarded (possibly translated) address |
| rsp_dram | output | 1 | Request goes to DRAM |
| rsp_blocked | output | 1 | Request refused |
| cfg_err | output | 1 | Open and close both set |

## Verification
The assertions assume that the configured segment window overlaps neither the high bus range nor the low window. Under that assumption, a DRAM-bound output can never land in the high bus range, and each address hits at most one window. The bench only programs segment tops near 0x7C00_0000, or a tiny top of low memory that disables the segment, so it stays within this assumption. The configuration is always held stable through an idle cycle before each request, except in the directed test that deliberately changes it while the strobe is high.

// File: rtl/smmdec_pkg.sv
package smmdec_pkg;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_LOW  = 2'd1,
        WIN_HIGH = 2'd2,
        WIN_SEG  = 2'd3
    } win_e;

    localparam logic [1:0] SEG_SEL_1M  = 2'b00;
    localparam logic [1:0] SEG_SEL_2M  = 2'b01;
    localparam logic [1:0] SEG_SEL_8M  = 2'b10;
    localparam logic [1:0] SEG_SEL_RSV = 2'b11;

    localparam int SEG_SHIFT_1M = 20;
    localparam int SEG_SHIFT_2M = 21;
    localparam int SEG_SHIFT_8M = 23;

endpackage

// File: rtl/smmdec_cfg.sv
module smmdec_cfg
    import smmdec_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          cfg_low_en,
    input  logic          cfg_high_en,
    input  logic          cfg_seg_en,
    input  logic          cfg_open,
    input  logic          cfg_close,
    input  logic [AW-1:0] cfg_tolm,
    input  logic [AW-1:0] cfg_stolen,
    input  logic [1:0]    cfg_seg_sel,
    output logic          low_en,
    output logic          high_en,
    output logic          seg_ok,
    output logic [AW-1:0] seg_base,
    output logic [AW-1:0] seg_top,
    output logic          open_eff,
    output logic          close_eff,
    output logic          cfg_err
);

    typedef struct packed {
        logic          low_en;
        logic          high_en;
        logic          seg_ok;
        logic [AW-1:0] seg_base;
        logic [AW-1:0] seg_top;
        logic          open_eff;
        logic          close_eff;
        logic          err;
    } shadow_t;

    shadow_t sh_d, sh_q;

    logic [AW:0]   top_wide;
    logic [AW:0]   base_wide;
    logic [AW-1:0] seg_size;
    logic          size_legal;

    always_comb begin
        seg_size   = '0;
        size_legal = 1'b1;
        case (cfg_seg_sel)
            SEG_SEL_1M: seg_size[SEG_SHIFT_1M] = 1'b1;
            SEG_SEL_2M: seg_size[SEG_SHIFT_2M] = 1'b1;
            SEG_SEL_8M: seg_size[SEG_SHIFT_8M] = 1'b1;
            default:    size_legal = 1'b0;
        endcase
    end

    always_comb begin
        top_wide  = {1'b0, cfg_tolm} - {1'b0, cfg_stolen};
        base_wide = {1'b0, top_wide[AW-1:0]} - {1'b0, seg_size};

        sh_d = sh_q;
        if (!req_valid) begin
            sh_d.low_en    = cfg_low_en;
            sh_d.high_en   = cfg_high_en;
            sh_d.seg_ok    = cfg_seg_en && size_legal && !top_wide[AW] && !base_wide[AW];
            sh_d.seg_top   = top_wide[AW-1:0];
            sh_d.seg_base  = base_wide[AW-1:0];
            sh_d.err       = cfg_open && cfg_close;
            sh_d.open_eff  = cfg_open && !cfg_close;
            sh_d.close_eff = cfg_close;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign low_en    = sh_q.low_en;
    assign high_en   = sh_q.high_en;
    assign seg_ok    = sh_q.seg_ok;
    assign seg_base  = sh_q.seg_base;
    assign seg_top   = sh_q.seg_top;
    assign open_eff  = sh_q.open_eff;
    assign close_eff = sh_q.close_eff;
    assign cfg_err   = sh_q.err;

    // R5: an illegal pair sampled in an idle cycle raises the error flag
    p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && cfg_open && cfg_close) |=> (cfg_err && !open_eff && close_eff));

    // R5: a legal pair sampled in an idle cycle clears it
    p_err_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !(cfg_open && cfg_close)) |=> !cfg_err);

    // R10: shadow state never moves while a request is strobed
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ($stable(cfg_err) && $stable(seg_base) && $stable(low_en)));

endmodule

// File: rtl/smmdec_window.sv
module smmdec_window
    import smmdec_pkg::*;
#(
    parameter int            AW        = 32,
    parameter logic [AW-1:0] LOW_FIRST  = 32'h000A_0000,
    parameter logic [AW-1:0] LOW_LAST   = 32'h000B_FFFF,
    parameter logic [AW-1:0] HIGH_FIRST = 32'hFEDA_0000,
    parameter logic [AW-1:0] HIGH_LAST  = 32'hFEDB_FFFF
) (
    input  logic [AW-1:0] addr,
    input  logic          low_en,
    input  logic          high_en,
    input  logic          seg_ok,
    input  logic [AW-1:0] seg_base,
    input  logic [AW-1:0] seg_top,
    output win_e          win
);

    localparam int NFIX = 2;
    localparam logic [AW-1:0] FIX_FIRST [NFIX] = '{LOW_FIRST, HIGH_FIRST};
    localparam logic [AW-1:0] FIX_LAST  [NFIX] = '{LOW_LAST,  HIGH_LAST};

    logic [NFIX-1:0] fix_en;
    logic [NFIX-1:0] fix_hit;
    logic            seg_hit;

    assign fix_en = {high_en, low_en};

    for (genvar gi = 0; gi < NFIX; gi++) begin : g_fixed
        assign fix_hit[gi] = fix_en[gi] &&
                             (addr >= FIX_FIRST[gi]) &&
                             (addr <= FIX_LAST[gi]);
    end

    assign seg_hit = seg_ok && (addr >= seg_base) && (addr < seg_top);

    // fixed windows take priority over the computed segment
    always_comb begin
        if (fix_hit[0])      win = WIN_LOW;
        else if (fix_hit[1]) win = WIN_HIGH;
        else if (seg_hit)    win = WIN_SEG;
        else                 win = WIN_NONE;
    end

endmodule

// File: rtl/smmdec_route.sv
module smmdec_route
    import smmdec_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] HIGH_OFS = 32'hFED0_0000
) (
    input  win_e          win,
    input  logic [AW-1:0] addr,
    input  logic          smm,
    input  logic          code,
    input  logic          open_eff,
    input  logic          close_eff,
    output logic [AW-1:0] out_addr,
    output logic          to_dram,
    output logic          blocked
);

    logic reach;
    logic data_shut;

    assign reach     = smm || open_eff;
    assign data_shut = close_eff && !code;

    always_comb begin
        out_addr = addr;
        to_dram  = 1'b0;
        blocked  = 1'b0;
        case (win)
            WIN_LOW: begin
                to_dram = reach && !data_shut;
            end
            WIN_HIGH: begin
                if (reach && !data_shut) begin
                    to_dram  = 1'b1;
                    out_addr = addr - HIGH_OFS;
                end else begin
                    blocked = 1'b1;
                end
            end
            WIN_SEG: begin
                to_dram = reach;
                blocked = !reach;
            end
            default: begin
                to_dram = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/smm_window_decoder.sv
module smm_window_decoder
    import smmdec_pkg::*;
#(
    parameter int            AW         = 32,
    parameter logic [AW-1:0] LOW_FIRST  = 32'h000A_0000,
    parameter logic [AW-1:0] LOW_LAST   = 32'h000B_FFFF,
    parameter logic [AW-1:0] HIGH_FIRST = 32'hFEDA_0000,
    parameter logic [AW-1:0] HIGH_LAST  = 32'hFEDB_FFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_smm,
    input  logic          req_code,
    input  logic          cfg_low_en,
    input  logic          cfg_high_en,
    input  logic          cfg_seg_en,
    input  logic          cfg_open,
    input  logic          cfg_close,
    input  logic [AW-1:0] cfg_tolm,
    input  logic [AW-1:0] cfg_stolen,
    input  logic [1:0]    cfg_seg_sel,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_addr,
    output logic          rsp_dram,
    output logic          rsp_blocked,
    output logic          cfg_err
);

    localparam logic [AW-1:0] HIGH_OFS = HIGH_FIRST - LOW_FIRST;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic          dram;
        logic          blocked;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic          sh_low_en, sh_high_en, sh_seg_ok;
    logic [AW-1:0] sh_seg_base, sh_seg_top;
    logic          sh_open, sh_close;
    win_e          win;
    logic [AW-1:0] rt_addr;
    logic          rt_dram, rt_blocked;

    smmdec_cfg #(.AW(AW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .cfg_low_en (cfg_low_en),
        .cfg_high_en(cfg_high_en),
        .cfg_seg_en (cfg_seg_en),
        .cfg_open   (cfg_open),
        .cfg_close  (cfg_close),
        .cfg_tolm   (cfg_tolm),
        .cfg_stolen (cfg_stolen),
        .cfg_seg_sel(cfg_seg_sel),
        .low_en     (sh_low_en),
        .high_en    (sh_high_en),
        .seg_ok     (sh_seg_ok),
        .seg_base   (sh_seg_base),
        .seg_top    (sh_seg_top),
        .open_eff   (sh_open),
        .close_eff  (sh_close),
        .cfg_err    (cfg_err)
    );

    smmdec_window #(
        .AW(AW), .LOW_FIRST(LOW_FIRST), .LOW_LAST(LOW_LAST),
        .HIGH_FIRST(HIGH_FIRST), .HIGH_LAST(HIGH_LAST)
    ) u_window (
        .addr    (req_addr),
        .low_en  (sh_low_en),
        .high_en (sh_high_en),
        .seg_ok  (sh_seg_ok),
        .seg_base(sh_seg_base),
        .seg_top (sh_seg_top),
        .win     (win)
    );

    smmdec_route #(.AW(AW), .HIGH_OFS(HIGH_OFS)) u_route (
        .win      (win),
        .addr     (req_addr),
        .smm      (req_smm),
        .code     (req_code),
        .open_eff (sh_open),
        .close_eff(sh_close),
        .out_addr (rt_addr),
        .to_dram  (rt_dram),
        .blocked  (rt_blocked)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.addr    = rt_addr;
            rsp_d.dram    = rt_dram;
            rsp_d.blocked = rt_blocked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_addr    = rsp_q.addr;
    assign rsp_dram    = rsp_q.dram;
    assign rsp_blocked = rsp_q.blocked;

    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_dram && rsp_blocked));

    p_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_addr) && $stable(rsp_dram)
                        && $stable(rsp_blocked)));

    p_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && win == WIN_NONE) |=>
            (rsp_addr == $past(req_addr) && !rsp_dram && !rsp_blocked));

    p_deny_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_smm && !sh_open) |=> !rsp_dram);

    p_noalias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_dram |-> !((rsp_addr >= HIGH_FIRST) && (rsp_addr <= HIGH_LAST)));

endmodule

// File: tb/smm_window_decoder_bench.sv
module smm_window_decoder_bench;

    typedef struct packed {
        logic [2:0]  en;      // {low, high, seg}
        logic        open;
        logic        close;
        logic [31:0] tolm;
        logic [31:0] stolen;
        logic [1:0]  sel;
        logic        smm;
        logic        code;
        logic [31:0] addr;
        logic        e_dram;
        logic        e_blk;
        logic [31:0] e_addr;
        logic [3:0]  req;
    } vec_t;

    localparam logic [31:0] TM = 32'h8000_0000;
    localparam logic [31:0] ST = 32'h0400_0000;
    localparam int NV = 27;

    localparam vec_t VECS [NV] = '{
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b00, 1'b1, 1'b0, 32'h000A_0000, 1'b1, 1'b0, 32'h000A_0000, 4'd2}, // R2 low edge
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b00, 1'b1, 1'b0, 32'h000B_FFFF, 1'b1, 1'b0, 32'h000B_FFFF, 4'd2}, // R2 high edge
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b00, 1'b1, 1'b0, 32'h000C_0000, 1'b0, 1'b0, 32'h000C_0000, 4'd9}, // R9
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b00, 1'b1, 1'b0, 32'h0009_FFFF, 1'b0, 1'b0, 32'h0009_FFFF, 4'd9}, // R9
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b00, 1'b1, 1'b0, 32'hFEDA_0000, 1'b1, 1'b0, 32'h000A_0000, 4'd3}, // R3
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b00, 1'b1, 1'b1, 32'hFEDB_1234, 1'b1, 1'b0, 32'h000B_1234, 4'd3}, // R3
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b00, 1'b1, 1'b0, 32'hFEDC_0000, 1'b0, 1'b0, 32'hFEDC_0000, 4'd9}, // R9
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b00, 1'b1, 1'b0, 32'h7BF0_0000, 1'b1, 1'b0, 32'h7BF0_0000, 4'd4}, // R4 1M base
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b00, 1'b1, 1'b0, 32'h7BEF_FFFF, 1'b0, 1'b0, 32'h7BEF_FFFF, 4'd4}, // R4 below
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b00, 1'b1, 1'b0, 32'h7C00_0000, 1'b0, 1'b0, 32'h7C00_0000, 4'd4}, // R4 top excl
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b01, 1'b1, 1'b0, 32'h7BE0_0000, 1'b1, 1'b0, 32'h7BE0_0000, 4'd4}, // R4 2M
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b10, 1'b1, 1'b0, 32'h7B80_0000, 1'b1, 1'b0, 32'h7B80_0000, 4'd4}, // R4 8M
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b11, 1'b1, 1'b0, 32'h7BF0_0000, 1'b0, 1'b0, 32'h7BF0_0000, 4'd4}, // R4 reserved
        '{3'b111, 1'b0, 1'b0, 32'h0010_0000, 32'h0, 2'b10, 1'b1, 1'b0, 32'h0001_0000, 1'b0, 1'b0, 32'h0001_0000, 4'd4}, // R4 borrow
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b00, 1'b0, 1'b0, 32'h000A_1000, 1'b0, 1'b0, 32'h000A_1000, 4'd8}, // R8 legacy
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b00, 1'b0, 1'b1, 32'hFEDA_0000, 1'b0, 1'b1, 32'hFEDA_0000, 4'd8}, // R8 high
        '{3'b111, 1'b0, 1'b0, TM, ST, 2'b00, 1'b0, 1'b0, 32'h7BF0_0000, 1'b0, 1'b1, 32'h7BF0_0000, 4'd8}, // R8 seg
        '{3'b111, 1'b1, 1'b0, TM, ST, 2'b00, 1'b0, 1'b0, 32'hFEDA_0010, 1'b1, 1'b0, 32'h000A_0010, 4'd6}, // R6 high
        '{3'b111, 1'b1, 1'b0, TM, ST, 2'b00, 1'b0, 1'b0, 32'h7BF0_0040, 1'b1, 1'b0, 32'h7BF0_0040, 4'd6}, // R6 seg
        '{3'b111, 1'b1, 1'b0, TM, ST, 2'b00, 1'b0, 1'b0, 32'h000A_0040, 1'b1, 1'b0, 32'h000A_0040, 4'd6}, // R6 low
        '{3'b111, 1'b0, 1'b1, TM, ST, 2'b00, 1'b1, 1'b0, 32'h000A_2000, 1'b0, 1'b0, 32'h000A_2000, 4'd7}, // R7 low data
        '{3'b111, 1'b0, 1'b1, TM, ST, 2'b00, 1'b1, 1'b0, 32'hFEDA_2000, 1'b0, 1'b1, 32'hFEDA_2000, 4'd7}, // R7 high data
        '{3'b111, 1'b0, 1'b1, TM, ST, 2'b00, 1'b1, 1'b1, 32'hFEDA_2000, 1'b1, 1'b0, 32'h000A_2000, 4'd7}, // R7 code
        '{3'b111, 1'b0, 1'b1, TM, ST, 2'b00, 1'b1, 1'b0, 32'h7BF0_2000, 1'b1, 1'b0, 32'h7BF0_2000, 4'd7}, // R7 seg
        '{3'b111, 1'b1, 1'b1, TM, ST, 2'b00, 1'b0, 1'b0, 32'hFEDA_0000, 1'b0, 1'b1, 32'hFEDA_0000, 4'd5}, // R5 closed
        '{3'b000, 1'b0, 1'b0, TM, ST, 2'b00, 1'b1, 1'b0, 32'h000A_0000, 1'b0, 1'b0, 32'h000A_0000, 4'd11}, // R11 low off
        '{3'b101, 1'b0, 1'b0, TM, ST, 2'b00, 1'b1, 1'b0, 32'hFEDA_0000, 1'b0, 1'b0, 32'hFEDA_0000, 4'd11}  // R11 high off
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_smm = 1'b0, req_code = 1'b0;
    logic        cfg_low_en = 1'b0, cfg_high_en = 1'b0, cfg_seg_en = 1'b0;
    logic        cfg_open = 1'b0, cfg_close = 1'b0;
    logic [31:0] cfg_tolm = '0, cfg_stolen = '0;
    logic [1:0]  cfg_seg_sel = '0;
    logic        rsp_valid, rsp_dram, rsp_blocked, cfg_err;
    logic [31:0] rsp_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smm_window_decoder u_smm_window_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_smm(req_smm), .req_code(req_code), .cfg_low_en(cfg_low_en),
        .cfg_high_en(cfg_high_en), .cfg_seg_en(cfg_seg_en), .cfg_open(cfg_open),
        .cfg_close(cfg_close), .cfg_tolm(cfg_tolm), .cfg_stolen(cfg_stolen),
        .cfg_seg_sel(cfg_seg_sel), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_dram(rsp_dram), .rsp_blocked(rsp_blocked), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input vec_t v);
        {cfg_low_en, cfg_high_en, cfg_seg_en} = v.en;
        cfg_open = v.open; cfg_close = v.close;
        cfg_tolm = v.tolm; cfg_stolen = v.stolen; cfg_seg_sel = v.sel;
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        req_valid = 1'b0;
        set_cfg(v);
        @(negedge clk);
        req_valid = 1'b1; req_addr = v.addr; req_smm = v.smm; req_code = v.code;
        @(negedge clk);
        req_valid = 1'b0;
        check($sformatf("R%0d vec addr %h {valid,dram,blk,addr}", v.req, v.addr),
              {1'b1, rsp_valid, rsp_dram, rsp_blocked, rsp_addr},
              {1'b1, 1'b1, v.e_dram, v.e_blk, v.e_addr});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        vec_t w;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset outputs", {3'b0, rsp_valid, rsp_dram, rsp_blocked, cfg_err, rsp_addr[28:0]},
              36'h0);
        check("R1 reset addr", {4'h0, rsp_addr}, 36'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R5 error flag with both controls set, then cleared
        w = VECS[24];
        @(negedge clk); set_cfg(w);
        @(negedge clk);
        check("R5 cfg_err set", {35'h0, cfg_err}, 36'h1);
        w.close = 1'b0;
        @(negedge clk); set_cfg(w);
        @(negedge clk);
        check("R5 cfg_err clear", {35'h0, cfg_err}, 36'h0);

        // R10 idle hold: outputs keep last response, valid drops
        w = VECS[4];
        run_vec(w);
        @(negedge clk);
        check("R10 hold after idle", {1'b0, rsp_valid, rsp_dram, rsp_blocked, rsp_addr},
              {1'b0, 1'b0, 1'b1, 1'b0, 32'h000A_0000});

        // R10 config change during strobe is ignored
        w = VECS[0];
        @(negedge clk); req_valid = 1'b0; set_cfg(w);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h000A_0100; req_smm = 1'b1; req_code = 1'b0;
        cfg_low_en = 1'b0; cfg_close = 1'b1;
        @(negedge clk);
        check("R10 cfg ignored #1", {2'b0, rsp_valid, rsp_dram, rsp_addr},
              {2'b0, 1'b1, 1'b1, 32'h000A_0100});
        req_addr = 32'h000B_0000;
        @(negedge clk);
        check("R10 cfg ignored #2", {2'b0, rsp_valid, rsp_dram, rsp_addr},
              {2'b0, 1'b1, 1'b1, 32'h000B_0000});
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 cfg applied after idle (R11)", {2'b0, rsp_valid, rsp_dram, rsp_addr},
              {2'b0, 1'b1, 1'b0, 32'h000B_0000});

        // R12 exclusivity observed at the ports for a blocked case
        run_vec(VECS[15]);
        check("R12 dram/blocked exclusive", {34'h0, rsp_dram, rsp_blocked}, 36'h1);

        done = 1'b1;
        finish_run();
    end

endmodule